// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a parallel NOR-style memory. It watches bus write cycles, each carrying an address and a data byte. It recognises three program sequences:

- a single-word program, allowed only while a bypass mode input is high;
- a two-word page program;
- a four-word page program.

It gathers each page's addresses and data and checks that the page lies inside one aligned group. It then hands the page to a program controller. That controller updates a small internal array, one word after another. A cell can only lose 1 bits: the stored value becomes the old value ANDed with the written data.

While a program runs, or while an error is pending, every bus read returns a status word instead of array data. The status word has a busy flag, an error flag and a toggle flag. A reset command ends an error. The same command aborts a running page program, but it does not abort a single-word bypass program. A separate erase pulse returns the whole array to all ones. The long unlock sequences of a real part are outside this block. Bypass mode comes in on a plain input pin.

Top module: `pflash_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0 and every array location reads back as all ones (8'hFF). Reads in read mode return array data one cycle after the read strobe.
- R2: A program leaves each target word equal to its previous contents ANDed with the written data. A program never turns a 0 bit into a 1.
- R3: A one-cycle `erase_all` pulse while `busy` is low sets every word to 8'hFF. A pulse while `busy` is high has no effect.
- R4: With `bypass_en` high, a write of 8'hA0 and then one address/data write programs that single word. The second write starts the program. With `bypass_en` low, 8'hA0 is ignored and the next write programs nothing.
- R5: A write of 8'h50, then two address/data writes, programs two words. The third write starts the program.
- R6: A write of 8'h56, then four address/data writes, programs four words. The fifth write starts the program.
- R7: The page addresses must match in every bit except bit 0 (two-word page) or bits 1:0 (four-word page). On a mismatch the error flag is set, no program starts, and no array word changes.
- R8: While `busy` is high, a read returns a status word with bit 0 = 1 (busy) and bit 1 = 0 (error). Bit 2 (toggle) changes value on every such read. Bits 7:3 are 0.
- R9: `busy` stays high for exactly WORD_CYC cycles per programmed word, counted from the cycle after the starting write.
- R10: While the error flag is set, reads return the status word with bit 1 = 1 and bit 0 = 0. Every write except 8'hF0 is ignored. A write of 8'hF0 clears the flag and returns the block to read mode.
- R11: A write of 8'hF0 during a two- or four-word program stops it at once: `busy` falls the next cycle and words not yet programmed keep their values. During a bypass single-word program, 8'hF0 is ignored and the program completes.
- R12: In read mode, a setup byte other than 8'hA0, 8'h50, 8'h56 or 8'hF0 is ignored. The next write programs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_rd | input | 1 | Bus read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Word address of the bus cycle |
| bus_wdata | input | DATA_W | Write data or command byte |
| bypass_en | input | 1 | Bypass mode active: enables the single-word program |
| erase_all | input | 1 | Whole-array erase pulse |
| rd_data | output | DATA_W | Registered read result: array word or status |
| busy | output | 1 | Program controller running |

## Verification
The bench goes after the boundaries of the page rules. A page whose addresses break the grouping only in bit 2 or bit 3 must raise the error flag. A design that compares too few bits would program the stray word. One that compares too many would reject legal pages written in shuffled order.

Reprogramming a word that is already programmed shows whether cells are ANDed or overwritten. Erase pulses issued during a program show whether a busy array is protected.

An abort early in a four-word page must leave every word erased. The same reset command during a bypass program must not shorten it. A design that mixes up the two cases either leaves stray data or drops the bypass write.

Commands sent while an error is pending, and unknown setup bytes, must change nothing. A sequencer that falls through would start spurious programs.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Command byte values, decoded from the low byte of the write data
  localparam logic [7:0] CMD_BYPASS = 8'hA0;
  localparam logic [7:0] CMD_PAIR   = 8'h50;
  localparam logic [7:0] CMD_QUAD   = 8'h56;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  // Status word bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_TOG  = 2;

  // Largest page gathered by one command
  localparam int PAGE_MAX = 4;
  localparam int IDX_W    = $clog2(PAGE_MAX);

  typedef enum logic [1:0] {
    SEQ_READ    = 2'd0,
    SEQ_BYP     = 2'd1,
    SEQ_COLLECT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pfc_cmd_decode.sv
module pfc_cmd_decode
  import pfc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_wr_i,
  input  logic [ADDR_W-1:0]                   bus_addr_i,
  input  logic [DATA_W-1:0]                   bus_wdata_i,
  input  logic                                bypass_en_i,
  input  logic                                prog_busy_i,
  output logic                                start_o,
  output logic                                start_byp_o,
  output logic [2:0]                          start_len_o,
  output logic [PAGE_MAX-1:0][ADDR_W-1:0]     page_addr_o,
  output logic [PAGE_MAX-1:0][DATA_W-1:0]     page_data_o,
  output logic                                abort_o,
  output logic                                err_o
);

  seq_state_e                      st_q, st_d;
  logic [IDX_W-1:0]                cnt_q, cnt_d;
  logic [2:0]                      len_q, len_d;
  logic [PAGE_MAX-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_MAX-1:0][DATA_W-1:0] data_q, data_d;
  logic                            err_q, err_d;
  logic                            adj_ok;
  logic [7:0]                      cmd;

  assign cmd = bus_wdata_i[7:0];

  // Adjacency: all page addresses share the bits above the page index
  always_comb begin
    adj_ok = 1'b1;
    for (int i = 0; i < PAGE_MAX; i++) begin
      logic [ADDR_W-1:0] a;
      a = (i == int'(cnt_q)) ? bus_addr_i : addr_q[i];
      if (i < int'(len_q)) begin
        if (len_q == 3'd2) begin
          if (a[ADDR_W-1:1] != addr_q[0][ADDR_W-1:1]) adj_ok = 1'b0;
        end else begin
          if (a[ADDR_W-1:2] != addr_q[0][ADDR_W-1:2]) adj_ok = 1'b0;
        end
      end
    end
  end

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    len_d       = len_q;
    addr_d      = addr_q;
    data_d      = data_q;
    err_d       = err_q;
    start_o     = 1'b0;
    start_byp_o = 1'b0;
    abort_o     = 1'b0;
    if (bus_wr_i) begin
      if (prog_busy_i) begin
        abort_o = (cmd == CMD_RESET);
      end else begin
        case (st_q)
          SEQ_READ: begin
            if (err_q) begin
              if (cmd == CMD_RESET) err_d = 1'b0;
            end else begin
              case (cmd)
                CMD_BYPASS: begin
                  if (bypass_en_i) begin
                    st_d  = SEQ_BYP;
                    len_d = 3'd1;
                  end
                end
                CMD_PAIR: begin
                  st_d  = SEQ_COLLECT;
                  len_d = 3'd2;
                  cnt_d = '0;
                end
                CMD_QUAD: begin
                  st_d  = SEQ_COLLECT;
                  len_d = 3'd4;
                  cnt_d = '0;
                end
                default: ;
              endcase
            end
          end
          SEQ_BYP: begin
            addr_d[0]   = bus_addr_i;
            data_d[0]   = bus_wdata_i;
            start_o     = 1'b1;
            start_byp_o = 1'b1;
            st_d        = SEQ_READ;
          end
          SEQ_COLLECT: begin
            addr_d[cnt_q] = bus_addr_i;
            data_d[cnt_q] = bus_wdata_i;
            if ({1'b0, cnt_q} == len_q - 3'd1) begin
              st_d = SEQ_READ;
              if (adj_ok) start_o = 1'b1;
              else        err_d   = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: st_d = SEQ_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_READ;
      cnt_q  <= '0;
      len_q  <= 3'd1;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      addr_q <= addr_d;
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign start_len_o = len_q;
  assign page_addr_o = addr_d;
  assign page_data_o = data_d;
  assign err_o       = err_q;

endmodule

// File: rtl/pfc_prog_ctrl.sv
module pfc_prog_ctrl
  import pfc_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int WORD_CYC = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            start_byp_i,
  input  logic [2:0]                      start_len_i,
  input  logic [PAGE_MAX-1:0][ADDR_W-1:0] page_addr_i,
  input  logic [PAGE_MAX-1:0][DATA_W-1:0] page_data_i,
  input  logic                            abort_i,
  output logic                            busy_o,
  output logic                            we_o,
  output logic [ADDR_W-1:0]               we_addr_o,
  output logic [DATA_W-1:0]               we_data_o
);

  localparam int              CYC_W    = $clog2(WORD_CYC + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(WORD_CYC - 1);

  logic                            busy_q, busy_d;
  logic                            byp_q, byp_d;
  logic [2:0]                      len_q, len_d;
  logic [IDX_W-1:0]                idx_q, idx_d;
  logic [CYC_W-1:0]                cyc_q, cyc_d;
  logic [PAGE_MAX-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_MAX-1:0][DATA_W-1:0] data_q, data_d;
  logic                            kill, word_done;

  assign kill      = abort_i && !byp_q;
  assign word_done = busy_q && (cyc_q == CYC_LAST);

  always_comb begin
    busy_d = busy_q;
    byp_d  = byp_q;
    len_d  = len_q;
    idx_d  = idx_q;
    cyc_d  = cyc_q;
    addr_d = addr_q;
    data_d = data_q;
    if (start_i) begin
      busy_d = 1'b1;
      byp_d  = start_byp_i;
      len_d  = start_len_i;
      idx_d  = '0;
      cyc_d  = '0;
      addr_d = page_addr_i;
      data_d = page_data_i;
    end else if (busy_q) begin
      if (kill) begin
        busy_d = 1'b0;
      end else if (word_done) begin
        cyc_d = '0;
        if ({1'b0, idx_q} == len_q - 3'd1) busy_d = 1'b0;
        else                               idx_d  = idx_q + 1'b1;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      byp_q  <= 1'b0;
      len_q  <= 3'd1;
      idx_q  <= '0;
      cyc_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      byp_q  <= byp_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      cyc_q  <= cyc_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy_o    = busy_q;
  assign we_o      = word_done && !kill;
  assign we_addr_o = addr_q[idx_q];
  assign we_data_o = data_q[idx_q];

endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0][DATA_W-1:0] word_d;
  logic [DEPTH-1:0]             word_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    // Program can only clear bits; erase restores ones
    assign word_en[g] = erase_i || (we_i && (waddr_i == ADDR_W'(g)));
    assign word_d[g]  = erase_i ? {DATA_W{1'b1}} : (mem_q[g] & wdata_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mem_q[g] <= {DATA_W{1'b1}};
      else if (word_en[g]) mem_q[g] <= word_d[g];
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
  import pfc_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int WORD_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bypass_en,
  input  logic              erase_all,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  logic                            start, start_byp, abort, dec_err;
  logic [2:0]                      start_len;
  logic [PAGE_MAX-1:0][ADDR_W-1:0] page_addr;
  logic [PAGE_MAX-1:0][DATA_W-1:0] page_data;
  logic                            prog_we;
  logic [ADDR_W-1:0]               prog_addr;
  logic [DATA_W-1:0]               prog_data;
  logic [DATA_W-1:0]               arr_rdata;
  logic [DATA_W-1:0]               status;
  logic                            tog_q, tog_d;
  logic [DATA_W-1:0]               rd_q, rd_d;

  pfc_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bypass_en_i (bypass_en),
    .prog_busy_i (busy),
    .start_o     (start),
    .start_byp_o (start_byp),
    .start_len_o (start_len),
    .page_addr_o (page_addr),
    .page_data_o (page_data),
    .abort_o     (abort),
    .err_o       (dec_err)
  );

  pfc_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_CYC(WORD_CYC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .start_byp_i (start_byp),
    .start_len_i (start_len),
    .page_addr_i (page_addr),
    .page_data_i (page_data),
    .abort_i     (abort),
    .busy_o      (busy),
    .we_o        (prog_we),
    .we_addr_o   (prog_addr),
    .we_data_o   (prog_data)
  );

  pfc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (prog_we),
    .waddr_i (prog_addr),
    .wdata_i (prog_data),
    .erase_i (erase_all && !busy),
    .raddr_i (bus_addr),
    .rdata_o (arr_rdata)
  );

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_ERR]  = dec_err;
    status[ST_TOG]  = tog_q;
  end

  always_comb begin
    tog_d = tog_q;
    rd_d  = rd_q;
    if (bus_rd) begin
      rd_d = (busy || dec_err) ? status : arr_rdata;
      if (busy) tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      tog_q <= tog_d;
      rd_q  <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/pfc_seq_checker.sv
module pfc_seq_checker #(
  parameter int DATA_W   = 8,
  parameter int WORD_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic [DATA_W-1:0] rd_data,
  input logic              err,
  input logic              arr_we
);

  localparam int RUN_MAX = 4 * WORD_CYC;
  localparam int RUN_W   = $clog2(RUN_MAX + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_status_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rd) |=> (rd_data[0] && !rd_data[1]));

  assert_toggle_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rd && $past(busy && bus_rd)) |=> (rd_data[2] != $past(rd_data[2])));

  assert_err_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(bus_wr && bus_wdata[7:0] == 8'hF0)) |=> err);

  assert_no_prog_in_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  assert_write_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run_q) < RUN_MAX));

endmodule

bind pflash_cmd_seq pfc_seq_checker #(.DATA_W(DATA_W), .WORD_CYC(WORD_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .busy      (busy),
  .rd_data   (rd_data),
  .err       (dec_err),
  .arr_we    (prog_we)
);

// File: tb/pflash_cmd_seq_test.sv
module pflash_cmd_seq_test;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int WC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bypass_en = 1'b0, erase_all = 1'b0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [DW-1:0] model [1 << AW];

  pflash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .WORD_CYC(WC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bypass_en(bypass_en),
    .erase_all(erase_all), .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // All tasks are entered at a negative edge and return at one
  task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_erase();
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
  endtask

  task automatic expect_word(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] d;
    bread(a, d);
    check(d == model[a], req, d, model[a]);
  endtask

  function automatic logic [DW-1:0] prog_val(input logic [DW-1:0] old, input logic [DW-1:0] wd);
    return old & wd;
  endfunction

  initial begin
    logic [DW-1:0] d, d2;
    int n;
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    void'($urandom(32'h5EED));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    for (int i = 0; i < 4; i++) expect_word(AW'(i * 17), "R1 erased at reset");

    // R4 + R9 + R2: bypass single program
    bypass_en = 1'b1;
    bwrite(6'd0, 8'hA0);
    bwrite(6'd5, 8'h3C);
    wait_idle(n);
    check(n == WC, "R9 single busy cycles", n, WC);
    model[5] = prog_val(model[5], 8'h3C);
    expect_word(6'd5, "R4 bypass program");
    bwrite(6'd0, 8'hA0);
    bwrite(6'd5, 8'hA5);
    wait_idle(n);
    model[5] = prog_val(model[5], 8'hA5);
    expect_word(6'd5, "R2 and of old and new");

    // R4: A0 ignored without bypass mode
    bypass_en = 1'b0;
    bwrite(6'd0, 8'hA0);
    bwrite(6'd9, 8'h00);
    check(busy == 1'b0, "R4 no start without bypass", busy, 0);
    expect_word(6'd9, "R4 word untouched");
    bypass_en = 1'b1;

    // R12: unknown setup byte
    bwrite(6'd0, 8'h77);
    bwrite(6'd10, 8'h12);
    check(busy == 1'b0, "R12 no start", busy, 0);
    expect_word(6'd10, "R12 word untouched");

    // R5: two-word page
    bwrite(6'd0, 8'h50);
    bwrite(6'd13, 8'h22);
    check(busy == 1'b0, "R5 not busy before last word", busy, 0);
    bwrite(6'd12, 8'h11);
    wait_idle(n);
    check(n == 2 * WC, "R9 pair busy cycles", n, 2 * WC);
    model[12] = 8'h11; model[13] = 8'h22;
    expect_word(6'd12, "R5 pair word 0");
    expect_word(6'd13, "R5 pair word 1");

    // R6 + R8: four-word page, status reads while busy
    bwrite(6'd0, 8'h56);
    bwrite(6'd22, 8'h0F);
    bwrite(6'd20, 8'hF0);
    bwrite(6'd23, 8'h55);
    bwrite(6'd21, 8'h81);
    bread(6'd20, d);
    check((d & 8'hFB) == 8'h01, "R8 busy status", d & 8'hFB, 1);
    bread(6'd20, d2);
    check(d2[2] != d[2], "R8 toggle flips", d2, d ^ 8'h04);
    wait_idle(n);
    model[20] = 8'hF0; model[21] = 8'h81; model[22] = 8'h0F; model[23] = 8'h55;
    for (int i = 20; i < 24; i++) expect_word(AW'(i), "R6 quad word");

    // R7 + R10: adjacency violation on a pair
    bwrite(6'd0, 8'h50);
    bwrite(6'd14, 8'h00);
    bwrite(6'd16, 8'h00);
    check(busy == 1'b0, "R7 no start on bad pair", busy, 0);
    bread(6'd14, d);
    check((d & 8'hFB) == 8'h02, "R7 error status", d & 8'hFB, 2);
    bwrite(6'd0, 8'h50);
    bwrite(6'd14, 8'h00);
    bwrite(6'd15, 8'h00);
    bread(6'd14, d);
    check((d & 8'hFB) == 8'h02 && !busy, "R10 writes ignored in error", d & 8'hFB, 2);
    bwrite(6'd0, 8'hF0);
    expect_word(6'd14, "R10 read mode after reset cmd");
    expect_word(6'd15, "R10 no program during error");
    expect_word(6'd16, "R7 bad pair not written");

    // R7: bad quad breaks bit 2
    bwrite(6'd0, 8'h56);
    bwrite(6'd24, 8'h00);
    bwrite(6'd25, 8'h00);
    bwrite(6'd26, 8'h00);
    bwrite(6'd28, 8'h00);
    bread(6'd24, d);
    check((d & 8'hFB) == 8'h02, "R7 quad error status", d & 8'hFB, 2);
    bwrite(6'd0, 8'hF0);
    for (int i = 24; i < 29; i++) expect_word(AW'(i), "R7 bad quad not written");

    // R11: abort a quad early
    bwrite(6'd0, 8'h56);
    for (int i = 32; i < 36; i++) bwrite(AW'(i), 8'h00);
    bwrite(6'd0, 8'hF0);
    check(busy == 1'b0, "R11 abort drops busy", busy, 0);
    for (int i = 32; i < 36; i++) expect_word(AW'(i), "R11 aborted words unchanged");

    // R11: bypass program ignores reset command
    bwrite(6'd0, 8'hA0);
    bwrite(6'd40, 8'h5A);
    bwrite(6'd0, 8'hF0);
    check(busy == 1'b1, "R11 bypass not aborted", busy, 1);
    wait_idle(n);
    model[40] = 8'h5A;
    expect_word(6'd40, "R11 bypass completes");

    // R3: erase ignored while busy, then honoured when idle
    bwrite(6'd0, 8'h56);
    for (int i = 44; i < 48; i++) bwrite(AW'(i), 8'h3E);
    pulse_erase();
    wait_idle(n);
    for (int i = 44; i < 48; i++) model[i] = 8'h3E;
    expect_word(6'd5, "R3 erase ignored while busy");
    expect_word(6'd46, "R3 program survives busy erase");
    pulse_erase();
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    expect_word(6'd5, "R3 erase all");
    expect_word(6'd46, "R3 erase all");

    // Random programs against the model
    for (int it = 0; it < 60; it++) begin
      int kind, len;
      bit viol;
      logic [AW-1:0] base, perm;
      logic [AW-1:0] a [4];
      logic [DW-1:0] dv [4];
      kind = $urandom_range(2, 0);
      len  = (kind == 0) ? 1 : (kind == 1) ? 2 : 4;
      viol = (len > 1) && ($urandom_range(4, 0) == 0);
      base = AW'($urandom);
      base = (len == 4) ? (base & ~AW'(3)) : (len == 2) ? (base & ~AW'(1)) : base;
      perm = AW'($urandom) & AW'(len - 1);
      for (int k = 0; k < len; k++) begin
        a[k]  = base | (AW'(k) ^ perm);
        dv[k] = DW'($urandom);
      end
      if (viol) a[len - 1] = a[len - 1] ^ 6'h08;
      if (kind == 0) bwrite(6'd0, 8'hA0);
      else           bwrite(6'd0, (kind == 1) ? 8'h50 : 8'h56);
      for (int k = 0; k < len; k++) bwrite(a[k], dv[k]);
      if (viol) begin
        bread(a[0], d);
        check((d & 8'hFB) == 8'h02 && !busy, "R7 random violation", d, 2);
        bwrite(6'd0, 8'hF0);
        for (int k = 0; k < len; k++) expect_word(a[k], "R7 random untouched");
      end else begin
        wait_idle(n);
        check(n == len * WC, "R9 random busy cycles", n, len * WC);
        for (int k = 0; k < len; k++) model[a[k]] = prog_val(model[a[k]], dv[k]);
        for (int k = 0; k < len; k++) expect_word(a[k], "R2 random program");
      end
      if ($urandom_range(9, 0) == 0) begin
        pulse_erase();
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        expect_word(AW'($urandom), "R3 random erase");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule